// File: doc/BRIEF.md
# Hypervisor debug access trap decoder

This block is a purely combinational decision unit that sits beside the system-register access path of a core. Each access is presented with its current privilege level, security state and a register-class code, together with the hypervisor's trap controls. The block decides whether the access must trap to the hypervisor level and which syndrome class to report. It also says whether debug exceptions taken at guest levels are routed to the hypervisor. The control register storage and the exception entry itself are outside this block.

Five control inputs drive the decision: a channel trap, a ROM-address trap, a power-down-register trap, a general debug trap and a debug-routing bit. The routing bit and a global trap-general flag both make the ROM-address, power-down and general debug traps act as set. The stored control values are not touched, so a direct read of the control register still returns what software wrote. Traps on the channel data-transfer registers are dropped while the core is halted for debug. A higher-priority exception flag keeps the trap strobe low.

The access class codes are 0 none, 1 channel data transfer by coprocessor move, 2 channel data transfer by load/store, 3 channel status by move, 4 ROM address, 5 power-down, 6 other debug register and 7 reserved. Guest levels are 0 and 1. With the default parameter, the hypervisor level only counts as active in the non-secure state.

Top module: `trapdec`

## Requirements
- R1: An access at level 2 or 3 (el_i >= 2) never raises trap_o, and route_dbg_o is 0 there.
- R2: When the hypervisor is not active in the current state (hyp_en_i = 0, or ns_i = 0 with the default SEC_HYP = 0), trap_o and route_dbg_o are 0.
- R3: With route_i = 1 or tge_i = 1, classes 4, 5 and 6 trap as if their own trap bits were set, even when rom_trap_i, pdn_trap_i and dbg_trap_i are all 0.
- R4: The ROM-address trap (rom_trap_i) traps class 4 from both level 0 and level 1.
- R5: Class 5 traps only at level 1. A level-0 class-5 access never traps, whatever the controls.
- R6: The general debug trap (dbg_trap_i) traps classes 1, 2, 3 and 6, and does not trap classes 4 or 5.
- R7: The channel trap (chan_trap_i) traps classes 1, 2 and 3 only. Class 6 is not trapped by it.
- R8: While halt_i = 1, classes 1 and 2 never trap. Classes 3 to 6 are unaffected by halt_i.
- R9: syn_o is 6'h06 for a trapped class-2 access, 6'h05 for any other trapped access, and 6'h00 when trap_o = 0.
- R10: hi_pri_i = 1 holds trap_o at 0, and syn_o at 0 with it. route_dbg_o is unaffected.
- R11: route_dbg_o = route_i | tge_i when the access is at a guest level and the hypervisor is active; otherwise it is 0.
- R12: Class 0 and class 7 never trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| el_i | input | 2 | Current privilege level of the access |
| ns_i | input | 1 | 1 = non-secure state |
| hyp_en_i | input | 1 | Hypervisor level implemented and enabled |
| halt_i | input | 1 | Core is in debug halt state |
| tge_i | input | 1 | Global trap-general flag |
| chan_trap_i | input | 1 | Channel register trap control |
| rom_trap_i | input | 1 | ROM-address register trap control |
| pdn_trap_i | input | 1 | Power-down register trap control |
| dbg_trap_i | input | 1 | General debug register trap control |
| route_i | input | 1 | Debug-exception routing control |
| hi_pri_i | input | 1 | A higher-priority exception is pending |
| cls_i | input | 3 | Register class of the access (codes above) |
| trap_o | output | 1 | Access traps to the hypervisor |
| syn_o | output | 6 | Syndrome class of the trap, 0 when no trap |
| route_dbg_o | output | 1 | Guest debug exceptions go to the hypervisor |

## Verification
The block holds no state, so every fault shows at the ports in the same evaluation as the input change that exposes it. A broken force path only shows when the routing or trap-general input is set and the matching own trap bit is clear. A wrong class scope shows as a spurious or missing trap_o for one class code. A wrong halt, level or security qualifier shows only in the input combinations that involve that qualifier. An exhaustive sweep of every input combination against an independent model is therefore the deciding check, backed by directed cases for each rule.

// File: rtl/trapdec_pkg.sv
package trapdec_pkg;
  typedef enum logic [2:0] {
    CLS_NONE      = 3'd0,
    CLS_DTR_MOVE  = 3'd1,
    CLS_DTR_LDST  = 3'd2,
    CLS_CHAN_STAT = 3'd3,
    CLS_ROM       = 3'd4,
    CLS_PDN       = 3'd5,
    CLS_DBG       = 3'd6,
    CLS_RSVD      = 3'd7
  } acc_cls_e;

  localparam int CLS_W = $bits(acc_cls_e);
  localparam int NCLS  = 1 << CLS_W;
  localparam int SYN_W = 6;

  localparam logic [SYN_W-1:0] SYN_NONE = 6'h00;
  localparam logic [SYN_W-1:0] SYN_MOVE = 6'h05;
  localparam logic [SYN_W-1:0] SYN_LDST = 6'h06;

  typedef struct packed {
    logic chan;
    logic rom;
    logic pdn;
    logic dbg;
  } trap_ctl_t;
endpackage

// File: rtl/trapdec_ctx.sv
module trapdec_ctx #(
  parameter int EL_W         = 2,
  parameter int GUEST_MAX_EL = 1,
  parameter bit SEC_HYP      = 1'b0
) (
  input  logic [EL_W-1:0] el_i,
  input  logic            ns_i,
  input  logic            hyp_en_i,
  output logic            guest_o,
  output logic            el1_o,
  output logic            hyp_act_o
);
  localparam logic [EL_W-1:0] GUEST_TOP = EL_W'(GUEST_MAX_EL);
  localparam logic [EL_W-1:0] EL_ONE    = EL_W'(1);

  assign guest_o = (el_i <= GUEST_TOP);
  assign el1_o   = (el_i == EL_ONE);

  generate
    if (SEC_HYP) begin : g_any_state
      assign hyp_act_o = hyp_en_i;
    end else begin : g_ns_only
      assign hyp_act_o = hyp_en_i & ns_i;
    end
  endgenerate
endmodule

// File: rtl/trapdec_force.sv
module trapdec_force
  import trapdec_pkg::*;
(
  input  logic      tge_i,
  input  logic      route_i,
  input  trap_ctl_t ctl_i,
  output trap_ctl_t ctl_o,
  output logic      route_o
);
  logic force_all;

  // routing or trap-general overrides the three debug-register traps
  assign force_all  = tge_i | route_i;
  assign route_o    = force_all;
  assign ctl_o.chan = ctl_i.chan;
  assign ctl_o.rom  = ctl_i.rom | force_all;
  assign ctl_o.pdn  = ctl_i.pdn | force_all;
  assign ctl_o.dbg  = ctl_i.dbg | force_all;
endmodule

// File: rtl/trapdec_match.sv
module trapdec_match
  import trapdec_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  logic             el1_i,
  input  logic             halt_i,
  input  trap_ctl_t        ctl_i,
  output logic             hit_o,
  output logic             ldst_o
);
  logic [NCLS-1:0] hit_vec;

  function automatic logic cls_hit(input int k, input trap_ctl_t c,
                                   input logic el1, input logic halt);
    logic chan_any;
    chan_any = c.chan | c.dbg;
    case (k)
      int'(CLS_DTR_MOVE),
      int'(CLS_DTR_LDST):  cls_hit = chan_any & ~halt;
      int'(CLS_CHAN_STAT): cls_hit = chan_any;
      int'(CLS_ROM):       cls_hit = c.rom;
      int'(CLS_PDN):       cls_hit = c.pdn & el1;
      int'(CLS_DBG):       cls_hit = c.dbg;
      default:             cls_hit = 1'b0;
    endcase
  endfunction

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    assign hit_vec[k] = cls_hit(k, ctl_i, el1_i, halt_i);
  end

  assign hit_o  = hit_vec[cls_i];
  assign ldst_o = (cls_i == CLS_DTR_LDST);
endmodule

// File: rtl/trapdec_syn.sv
module trapdec_syn
  import trapdec_pkg::*;
(
  input  logic             trap_i,
  input  logic             ldst_i,
  output logic [SYN_W-1:0] syn_o
);
  always_comb begin
    if (!trap_i)     syn_o = SYN_NONE;
    else if (ldst_i) syn_o = SYN_LDST;
    else             syn_o = SYN_MOVE;
  end
endmodule

// File: rtl/trapdec.sv
module trapdec
  import trapdec_pkg::*;
#(
  parameter int EL_W         = 2,
  parameter int GUEST_MAX_EL = 1,
  parameter bit SEC_HYP      = 1'b0
) (
  input  logic [EL_W-1:0]  el_i,
  input  logic             ns_i,
  input  logic             hyp_en_i,
  input  logic             halt_i,
  input  logic             tge_i,
  input  logic             chan_trap_i,
  input  logic             rom_trap_i,
  input  logic             pdn_trap_i,
  input  logic             dbg_trap_i,
  input  logic             route_i,
  input  logic             hi_pri_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             trap_o,
  output logic [SYN_W-1:0] syn_o,
  output logic             route_dbg_o
);
  logic      guest, el1, hyp_act, route_eff, hit, ldst, trap;
  trap_ctl_t ctl_raw, ctl_eff;

  assign ctl_raw = '{chan: chan_trap_i, rom: rom_trap_i,
                     pdn: pdn_trap_i, dbg: dbg_trap_i};

  trapdec_ctx #(
    .EL_W(EL_W), .GUEST_MAX_EL(GUEST_MAX_EL), .SEC_HYP(SEC_HYP)
  ) u_ctx (
    .el_i(el_i), .ns_i(ns_i), .hyp_en_i(hyp_en_i),
    .guest_o(guest), .el1_o(el1), .hyp_act_o(hyp_act)
  );

  trapdec_force u_force (
    .tge_i(tge_i), .route_i(route_i), .ctl_i(ctl_raw),
    .ctl_o(ctl_eff), .route_o(route_eff)
  );

  trapdec_match u_match (
    .cls_i(cls_i), .el1_i(el1), .halt_i(halt_i), .ctl_i(ctl_eff),
    .hit_o(hit), .ldst_o(ldst)
  );

  assign trap = hit & guest & hyp_act & ~hi_pri_i;

  trapdec_syn u_syn (.trap_i(trap), .ldst_i(ldst), .syn_o(syn_o));

  assign trap_o      = trap;
  assign route_dbg_o = route_eff & guest & hyp_act;
endmodule

// File: rtl/trapdec_chk.sv
module trapdec_chk
  import trapdec_pkg::*;
#(
  parameter int EL_W         = 2,
  parameter int GUEST_MAX_EL = 1,
  parameter bit SEC_HYP      = 1'b0
) (
  input logic [EL_W-1:0]  el_i,
  input logic             ns_i,
  input logic             hyp_en_i,
  input logic             halt_i,
  input logic             tge_i,
  input logic             chan_trap_i,
  input logic             rom_trap_i,
  input logic             pdn_trap_i,
  input logic             dbg_trap_i,
  input logic             route_i,
  input logic             hi_pri_i,
  input logic [CLS_W-1:0] cls_i,
  input logic             trap_o,
  input logic [SYN_W-1:0] syn_o,
  input logic             route_dbg_o
);
  logic active;
  assign active = hyp_en_i & (ns_i | SEC_HYP) & (int'(el_i) <= GUEST_MAX_EL);

  always_comb begin
    // R10
    hipri_blocks_chk: assert (!(hi_pri_i && trap_o));
    // R1
    high_level_quiet_chk: assert (!(int'(el_i) > GUEST_MAX_EL && (trap_o || route_dbg_o)));
    // R2
    hyp_off_quiet_chk: assert (!((!hyp_en_i || (!ns_i && !SEC_HYP)) && (trap_o || route_dbg_o)));
    // R9
    syn_idle_chk: assert (trap_o || syn_o == SYN_NONE);
    // R9
    syn_ldst_chk: assert (!(trap_o && cls_i == CLS_DTR_LDST) || syn_o == SYN_LDST);
    // R5
    pdn_el0_chk: assert (!(el_i == '0 && cls_i == CLS_PDN && trap_o));
    // R8
    halt_dtr_chk: assert (!(halt_i && trap_o &&
                           (cls_i == CLS_DTR_MOVE || cls_i == CLS_DTR_LDST)));
    // R12
    no_class_chk: assert (!(trap_o && (cls_i == CLS_NONE || cls_i == CLS_RSVD)));
    // R3
    force_dbg_chk: assert (!(active && !hi_pri_i && (route_i || tge_i) &&
                            cls_i == CLS_DBG) || trap_o);
    // R11
    route_chk: assert (route_dbg_o == (active && (route_i || tge_i)));
  end
endmodule

bind trapdec trapdec_chk #(
  .EL_W(EL_W), .GUEST_MAX_EL(GUEST_MAX_EL), .SEC_HYP(SEC_HYP)
) u_chk (.*);

// File: tb/trapdec_tb.sv
`timescale 1ns/1ps
module trapdec_tb;
  logic       clk = 1'b0;
  logic [1:0] el;
  logic       ns, hyp, halt, tge, chan, rom, pdn, dbg, route, hp;
  logic [2:0] cls;
  logic       trap;
  logic [5:0] syn;
  logic       rdbg;
  int         n_chk = 0, n_bad = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  trapdec u_dut (
    .el_i(el), .ns_i(ns), .hyp_en_i(hyp), .halt_i(halt), .tge_i(tge),
    .chan_trap_i(chan), .rom_trap_i(rom), .pdn_trap_i(pdn),
    .dbg_trap_i(dbg), .route_i(route), .hi_pri_i(hp), .cls_i(cls),
    .trap_o(trap), .syn_o(syn), .route_dbg_o(rdbg)
  );

  // independent model from the requirement list: {route, trap, syn}
  function automatic logic [7:0] model(input logic [14:0] v);
    logic [1:0] e; logic n, h, hl, tg, ch, ro, pd, db, rt, hi; logic [2:0] c;
    logic t, r, frc; logic [5:0] s;
    {e, n, h, hl, tg, ch, ro, pd, db, rt, hi, c} = v;
    frc = rt | tg;
    t = 1'b0;
    if (c == 3'd1 || c == 3'd2) t = (ch | db | frc) & !hl;     // R6 R7 R8 R3
    else if (c == 3'd3)        t = ch | db | frc;
    else if (c == 3'd4)        t = ro | frc;                  // R4
    else if (c == 3'd5)        t = (pd | frc) & (e == 2'd1);  // R5
    else if (c == 3'd6)        t = db | frc;
    if (e >= 2'd2 || !h || !n || hi) t = 1'b0;               // R1 R2 R10
    r = frc && e < 2'd2 && h && n;                             // R11
    s = !t ? 6'h00 : (c == 3'd2 ? 6'h06 : 6'h05);              // R9
    return {r, t, s};
  endfunction

  task automatic apply(input logic [14:0] v);
    {el, ns, hyp, halt, tge, chan, rom, pdn, dbg, route, hp, cls} = v;
    #2;
  endtask

  task automatic check(input string req, input logic [14:0] v);
    logic [7:0] exp, act;
    apply(v);
    exp = model(v);
    act = {rdbg, trap, syn};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s vec=%h act route=%b trap=%b syn=%h exp route=%b trap=%b syn=%h",
               req, v, act[7], act[6], act[5:0], exp[7], exp[6], exp[5:0]);
    end
  endtask

  task automatic expect_out(input string req, input logic [14:0] v,
                            input logic et, input logic [5:0] es, input logic er);
    apply(v);
    n_chk++;
    if (trap !== et || syn !== es || rdbg !== er) begin
      n_bad++;
      $display("FAIL %s act trap=%b syn=%h route=%b exp trap=%b syn=%h route=%b",
               req, trap, syn, rdbg, et, es, er);
    end
  endtask

  // vector layout: el[2] ns hyp halt tge chan rom pdn dbg route hp cls[3]
  function automatic logic [14:0] mk(input logic [1:0] e, input logic h,
      input logic hl, input logic tg, input logic ch, input logic ro,
      input logic pd, input logic db, input logic rt, input logic hi,
      input logic [2:0] c);
    return {e, 1'b1, h, hl, tg, ch, ro, pd, db, rt, hi, c};
  endfunction

  task automatic t_idle();
    expect_out("R12 idle", 15'd0, 1'b0, 6'h00, 1'b0);
  endtask

  task automatic t_levels();
    expect_out("R1 el2", mk(2'd2,1,0,1,1,1,1,1,1,0,3'd6), 1'b0, 6'h00, 1'b0);
    expect_out("R1 el3", mk(2'd3,1,0,1,1,1,1,1,1,0,3'd4), 1'b0, 6'h00, 1'b0);
  endtask

  task automatic t_hyp_off();
    expect_out("R2 hyp_off", mk(2'd1,0,0,1,1,1,1,1,1,0,3'd6), 1'b0, 6'h00, 1'b0);
    expect_out("R2 secure", {2'd1,1'b0,1'b1,11'b0_1111_1_0_110}, 1'b0, 6'h00, 1'b0);
  endtask

  task automatic t_force();
    expect_out("R3 route_dbg", mk(2'd0,1,0,0,0,0,0,0,1,0,3'd6), 1'b1, 6'h05, 1'b1);
    expect_out("R3 tge_rom",   mk(2'd0,1,0,1,0,0,0,0,0,0,3'd4), 1'b1, 6'h05, 1'b1);
    expect_out("R3 tge_pdn",   mk(2'd1,1,0,1,0,0,0,0,0,0,3'd5), 1'b1, 6'h05, 1'b1);
  endtask

  task automatic t_rom();
    expect_out("R4 el0", mk(2'd0,1,0,0,0,1,0,0,0,0,3'd4), 1'b1, 6'h05, 1'b0);
    expect_out("R4 el1", mk(2'd1,1,0,0,0,1,0,0,0,0,3'd4), 1'b1, 6'h05, 1'b0);
  endtask

  task automatic t_pdn();
    expect_out("R5 el1", mk(2'd1,1,0,0,0,0,1,0,0,0,3'd5), 1'b1, 6'h05, 1'b0);
    expect_out("R5 el0", mk(2'd0,1,0,1,1,1,1,1,1,0,3'd5), 1'b0, 6'h00, 1'b1);
  endtask

  task automatic t_scope();
    expect_out("R6 dbg_rom", mk(2'd1,1,0,0,0,0,0,1,0,0,3'd4), 1'b0, 6'h00, 1'b0);
    expect_out("R6 dbg_pdn", mk(2'd1,1,0,0,0,0,0,1,0,0,3'd5), 1'b0, 6'h00, 1'b0);
    expect_out("R6 dbg_stat", mk(2'd0,1,0,0,0,0,0,1,0,0,3'd3), 1'b1, 6'h05, 1'b0);
    expect_out("R7 chan_dbg", mk(2'd1,1,0,0,1,0,0,0,0,0,3'd6), 1'b0, 6'h00, 1'b0);
    expect_out("R7 chan_move", mk(2'd0,1,0,0,1,0,0,0,0,0,3'd1), 1'b1, 6'h05, 1'b0);
  endtask

  task automatic t_halt();
    expect_out("R8 move", mk(2'd1,1,1,0,1,0,0,1,0,0,3'd1), 1'b0, 6'h00, 1'b0);
    expect_out("R8 ldst", mk(2'd1,1,1,0,1,0,0,1,0,0,3'd2), 1'b0, 6'h00, 1'b0);
    expect_out("R8 stat", mk(2'd1,1,1,0,1,0,0,0,0,0,3'd3), 1'b1, 6'h05, 1'b0);
  endtask

  task automatic t_syn();
    expect_out("R9 ldst", mk(2'd0,1,0,0,1,0,0,0,0,0,3'd2), 1'b1, 6'h06, 1'b0);
  endtask

  task automatic t_hipri();
    expect_out("R10 hp", mk(2'd1,1,0,0,1,1,1,1,1,1,3'd2), 1'b0, 6'h00, 1'b1);
  endtask

  task automatic t_route();
    expect_out("R11 route", mk(2'd0,1,0,0,0,0,0,0,1,0,3'd0), 1'b0, 6'h00, 1'b1);
    expect_out("R12 rsvd", mk(2'd1,1,0,1,1,1,1,1,1,0,3'd7), 1'b0, 6'h00, 1'b1);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 32768; i++) check("R9 sweep", 15'(i));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act cyc=%0d exp done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    apply(15'd0);
    #1;
    t_idle(); t_levels(); t_hyp_off(); t_force(); t_rom(); t_pdn();
    t_scope(); t_halt(); t_syn(); t_hipri(); t_route(); t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule